// File: doc/BRIEF.md
# Multi-channel DAC serial register slave

This block is the digital control front end of a multi-channel digital-to-analog converter. A host drives it over a four-wire SPI link in mode 0: clock idle low, bits taken on the rising clock edge, most significant bit first. Each transfer framed by chip select carries one 24-bit word. The word splits into a two-bit command, a six-bit address and a sixteen-bit value. The block keeps one data, one offset and one gain register for every channel, a control register, and one offset register for each reference group. All register contents, a per-channel view of the group offset that applies to each channel, and a power-down flag appear as outputs for the analog side to use.

The host reads a register by sending a readback request. During the next chip-select period the block shifts the selected register out on MISO. The SPI pins are brought into the system clock domain through two-stage synchronizers. The SCLK rate must therefore stay well below the system clock rate. The channel count, the converter resolution (16 or 14 bits), the number of channels per reference group and the number of group offset registers are all parameters.

Top module: `dacspi_regslave`

## Requirements
- R1: A frame is a chip-select-low period with exactly 24 rising SCLK edges. The word is taken MSB first and splits into command [23:22], address [21:16] and value [15:0]. Command 3 writes the value to the data register of channel n when the address is n+8. The value is stored left-aligned: with DATA_W=14, bits [1:0] are stored as 0.
- R2: Command 2 writes the offset register and command 1 writes the gain register of channel n at address n+8. Both use the same left-aligned masking as R1, and neither touches the other banks.
- R3: A chip-select period with any count of rising SCLK edges other than 24 is dropped. This includes 23 and 25. It changes no register and does not arm a readback.
- R4: After reset, every data register, offset register, group offset register and the control register are 0. Every gain register holds all ones in its DATA_W upper bits (16'hFFFF for 16 bits, 16'hFFFC for 14 bits). MISO is 0.
- R5: Command 0 at address 1 writes the full 16-bit control register. pwr_down follows bit 0 of that register.
- R6: Command 0 at address 2+g, for g below NUM_GRP, writes value bits [13:0] into group offset register g. Value bits [15:14] are dropped.
- R7: Channel n uses group offset register min(n / CH_PER_GRP, NUM_GRP-1). chan_grp_offset shows that register for every channel.
- R8: Command 0 at address 5 is a readback request. Bits [15:13] give the kind: 0 = channel data, 2 = channel offset, 3 = channel gain, 4 = special register. Bits [12:7] give the target address. The next chip-select period shifts out a 24-bit word whose bits [23:16] are 0 and whose bits [15:0] hold the target register, one bit per falling SCLK edge, MSB first. Group offsets read back zero-extended.
- R9: A readback result appears only in the chip-select period right after the request. Every other period shifts out zeros, and MISO is 0 while chip select is high.
- R10: A write to an unmapped target changes no state. This covers commands 1 to 3 outside channel addresses 8 to 8+NUM_CH-1, command 0 at address 0, and command 0 at any address not named in R5, R6 or R8.
- R11: A readback of kind 1, of kinds 5 to 7, or of an unmapped target returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial readback data to host |
| chan_data | output | NUM_CH*16 | Data registers, channel n in bits [16n+15:16n] |
| chan_offset | output | NUM_CH*16 | Channel offset registers, same packing |
| chan_gain | output | NUM_CH*16 | Channel gain registers, same packing |
| grp_offset | output | NUM_GRP*14 | Group offset registers, group g in bits [14g+13:14g] |
| chan_grp_offset | output | NUM_CH*14 | Group offset that applies to each channel |
| pwr_down | output | 1 | Global power-down flag |

## Verification
A committed write reaches the register outputs on the fourth rising clock edge after chip select rises. That count is two synchronizer stages, one edge to latch the frame and one to write the register. The bench therefore reads the outputs eight clock cycles after it deselects. A MISO bit becomes valid three edges after chip select falls or after a falling SCLK edge. The bench holds each SCLK phase for five cycles and samples MISO on the last falling clock edge before it raises SCLK. A second instance built for 14-bit resolution shares the same serial lines, so every sweep also checks the left-aligned masking against an expected value worked out arithmetically.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;
  localparam int FRAME_W  = 24;
  localparam int FIELD_W  = 16;
  localparam int ADDR_W   = 6;
  localparam int GOFS_W   = 14;
  localparam int CH_BASE  = 8;

  // special-function addresses (command 0)
  localparam int SF_CTRL  = 1;
  localparam int SF_GOFS0 = 2;
  localparam int SF_RDREQ = 5;
  localparam int PWR_BIT  = 0;

  // readback kinds
  localparam logic [2:0] RB_DATA    = 3'd0;
  localparam logic [2:0] RB_OFFSET  = 3'd2;
  localparam logic [2:0] RB_GAIN    = 3'd3;
  localparam logic [2:0] RB_SPECIAL = 3'd4;

  typedef enum logic [1:0] {
    CMD_SPECIAL = 2'd0,
    CMD_GAIN    = 2'd1,
    CMD_OFFSET  = 2'd2,
    CMD_DATA    = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [1:0]         cmd;
    logic [ADDR_W-1:0]  addr;
    logic [FIELD_W-1:0] val;
  } frame_t;
endpackage

// File: rtl/dacspi_pin_sync.sv
module dacspi_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic sclk_pin,
  input  logic cs_n_pin,
  input  logic mosi_pin,
  output logic cs_hi,
  output logic cs_rise,
  output logic cs_fall,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_lvl
);
  // bit 2 = chip select, bit 1 = sclk, bit 0 = mosi
  localparam logic [2:0] IDLE = 3'b100;

  logic [2:0] st0, st1;
  logic [2:1] st2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st0 <= IDLE;
      st1 <= IDLE;
      st2 <= IDLE[2:1];
    end else begin
      st0 <= {cs_n_pin, sclk_pin, mosi_pin};
      st1 <= st0;
      st2 <= st1[2:1];
    end
  end

  assign cs_hi     = st1[2];
  assign cs_rise   = st1[2] & ~st2[2];
  assign cs_fall   = ~st1[2] & st2[2];
  assign sclk_rise = st1[1] & ~st2[1];
  assign sclk_fall = ~st1[1] & st2[1];
  assign mosi_lvl  = st1[0];
endmodule

// File: rtl/dacspi_frame_rx.sv
module dacspi_frame_rx
  import dacspi_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cs_hi,
  input  logic   cs_rise,
  input  logic   sclk_rise,
  input  logic   mosi_lvl,
  output frame_t frame_q,
  output logic   commit_q
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      bitcnt   <= '0;
      frame_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (cs_rise && bitcnt == CNT_W'(FRAME_W)) begin
        frame_q  <= frame_t'(shreg);
        commit_q <= 1'b1;
      end
      if (cs_hi) begin
        bitcnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_lvl};
        if (bitcnt != CNT_W'(CNT_SAT)) bitcnt <= bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dacspi_regbank.sv
module dacspi_regbank
  import dacspi_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DATA_W     = 16,
  parameter int CH_PER_GRP = 4,
  parameter int NUM_GRP    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  frame_t                      frame,
  input  logic                        commit,
  input  logic                        rb_take,
  output logic [NUM_CH*FIELD_W-1:0]   data_o,
  output logic [NUM_CH*FIELD_W-1:0]   ofs_o,
  output logic [NUM_CH*FIELD_W-1:0]   gain_o,
  output logic [NUM_GRP*GOFS_W-1:0]   gofs_o,
  output logic [NUM_CH*GOFS_W-1:0]    chan_gofs_o,
  output logic                        pwr_down_o,
  output logic [FIELD_W-1:0]          rb_word_o
);
  localparam logic [FIELD_W-1:0] KEEP_MASK = ~16'((1 << (FIELD_W - DATA_W)) - 1);
  localparam logic [ADDR_W:0]    CH_LO     = 7'(CH_BASE);
  localparam logic [ADDR_W:0]    CH_END    = 7'(CH_BASE + NUM_CH);

  logic               is_sf, ch_hit;
  logic [ADDR_W-1:0]  ch_off;
  logic [FIELD_W-1:0] wr_val;

  always_comb begin
    is_sf  = commit && frame.cmd == CMD_SPECIAL;
    ch_hit = commit && frame.cmd != CMD_SPECIAL &&
             {1'b0, frame.addr} >= CH_LO && {1'b0, frame.addr} < CH_END;
    ch_off = frame.addr - 6'(CH_BASE);
    wr_val = frame.val & KEEP_MASK;
  end

  // per-channel banks
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP_RAW = c / CH_PER_GRP;
    localparam int GRP     = (GRP_RAW < NUM_GRP) ? GRP_RAW : NUM_GRP - 1;
    logic [FIELD_W-1:0] dat_q, ofs_q, gain_q;
    logic               sel;
    assign sel = ch_hit && ch_off == 6'(c);

    always_ff @(posedge clk) begin
      if (rst) begin
        dat_q  <= '0;
        ofs_q  <= '0;
        gain_q <= KEEP_MASK;
      end else if (sel) begin
        case (frame.cmd)
          CMD_DATA:   dat_q  <= wr_val;
          CMD_OFFSET: ofs_q  <= wr_val;
          CMD_GAIN:   gain_q <= wr_val;
          default: ;
        endcase
      end
    end

    assign data_o[c*FIELD_W +: FIELD_W]     = dat_q;
    assign ofs_o[c*FIELD_W +: FIELD_W]      = ofs_q;
    assign gain_o[c*FIELD_W +: FIELD_W]     = gain_q;
    assign chan_gofs_o[c*GOFS_W +: GOFS_W]  = gofs_o[GRP*GOFS_W +: GOFS_W];
  end

  // group offset registers
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GOFS_W-1:0] gofs_q;
    always_ff @(posedge clk) begin
      if (rst)                                         gofs_q <= '0;
      else if (is_sf && frame.addr == 6'(SF_GOFS0 + g)) gofs_q <= frame.val[GOFS_W-1:0];
    end
    assign gofs_o[g*GOFS_W +: GOFS_W] = gofs_q;
  end

  // control register
  logic [FIELD_W-1:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (rst)                                     ctrl_q <= '0;
    else if (is_sf && frame.addr == 6'(SF_CTRL)) ctrl_q <= frame.val;
  end
  assign pwr_down_o = ctrl_q[PWR_BIT];

  // readback request capture
  logic              rb_pend;
  logic [2:0]        rb_sel;
  logic [ADDR_W-1:0] rb_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_pend <= 1'b0;
      rb_sel  <= '0;
      rb_tgt  <= '0;
    end else begin
      if (rb_take) rb_pend <= 1'b0;
      if (is_sf && frame.addr == 6'(SF_RDREQ)) begin
        rb_pend <= 1'b1;
        rb_sel  <= frame.val[15:13];
        rb_tgt  <= frame.val[12:7];
      end
    end
  end

  logic [FIELD_W-1:0] rb_mux;
  logic [ADDR_W-1:0]  tgt_off;
  logic               tgt_ch;

  always_comb begin
    rb_mux  = '0;
    tgt_off = rb_tgt - 6'(CH_BASE);
    tgt_ch  = {1'b0, rb_tgt} >= CH_LO && {1'b0, rb_tgt} < CH_END;
    for (int c = 0; c < NUM_CH; c++) begin
      if (tgt_ch && tgt_off == 6'(c)) begin
        case (rb_sel)
          RB_DATA:   rb_mux = data_o[c*FIELD_W +: FIELD_W];
          RB_OFFSET: rb_mux = ofs_o[c*FIELD_W +: FIELD_W];
          RB_GAIN:   rb_mux = gain_o[c*FIELD_W +: FIELD_W];
          default: ;
        endcase
      end
    end
    if (rb_sel == RB_SPECIAL) begin
      if (rb_tgt == 6'(SF_CTRL)) rb_mux = ctrl_q;
      for (int g = 0; g < NUM_GRP; g++) begin
        if (rb_tgt == 6'(SF_GOFS0 + g))
          rb_mux = {{(FIELD_W-GOFS_W){1'b0}}, gofs_o[g*GOFS_W +: GOFS_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rb_word_o <= '0;
    else     rb_word_o <= rb_pend ? rb_mux : '0;
  end
endmodule

// File: rtl/dacspi_tx.sv
module dacspi_tx
  import dacspi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_hi,
  input  logic               cs_fall,
  input  logic               sclk_fall,
  input  logic [FIELD_W-1:0] rb_word,
  output logic               miso
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)            sr <= '0;
    else if (cs_fall)   sr <= {{(FRAME_W-FIELD_W){1'b0}}, rb_word};
    else if (cs_hi)     sr <= '0;
    else if (sclk_fall) sr <= {sr[FRAME_W-2:0], 1'b0};
  end

  assign miso = sr[FRAME_W-1];
endmodule

// File: rtl/dacspi_regslave.sv
module dacspi_regslave
  import dacspi_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DATA_W     = 16,
  parameter int CH_PER_GRP = 4,
  parameter int NUM_GRP    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  output logic [NUM_CH*16-1:0]      chan_data,
  output logic [NUM_CH*16-1:0]      chan_offset,
  output logic [NUM_CH*16-1:0]      chan_gain,
  output logic [NUM_GRP*14-1:0]     grp_offset,
  output logic [NUM_CH*14-1:0]      chan_grp_offset,
  output logic                      pwr_down
);
  logic cs_hi, cs_rise, cs_fall, sclk_rise, sclk_fall, mosi_lvl;
  frame_t frame;
  logic commit;
  logic [FIELD_W-1:0] rb_word;

  dacspi_pin_sync u_sync (
    .clk(clk), .rst(rst),
    .sclk_pin(spi_sclk), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_lvl(mosi_lvl)
  );

  dacspi_frame_rx u_rx (
    .clk(clk), .rst(rst),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sclk_rise(sclk_rise), .mosi_lvl(mosi_lvl),
    .frame_q(frame), .commit_q(commit)
  );

  dacspi_regbank #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_PER_GRP(CH_PER_GRP), .NUM_GRP(NUM_GRP)
  ) u_bank (
    .clk(clk), .rst(rst),
    .frame(frame), .commit(commit), .rb_take(cs_fall),
    .data_o(chan_data), .ofs_o(chan_offset), .gain_o(chan_gain),
    .gofs_o(grp_offset), .chan_gofs_o(chan_grp_offset),
    .pwr_down_o(pwr_down), .rb_word_o(rb_word)
  );

  dacspi_tx u_tx (
    .clk(clk), .rst(rst),
    .cs_hi(cs_hi), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .rb_word(rb_word), .miso(spi_miso)
  );

  // frame fields brought out for the bound checker
  logic [1:0]        frm_cmd;
  logic [ADDR_W-1:0] frm_addr;
  logic              frm_val0;
  assign frm_cmd  = frame.cmd;
  assign frm_addr = frame.addr;
  assign frm_val0 = frame.val[PWR_BIT];
endmodule

// File: rtl/dacspi_regslave_chk.sv
module dacspi_regslave_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_hi,
  input logic       cs_rise,
  input logic       cs_fall,
  input logic       commit,
  input logic [1:0] frm_cmd,
  input logic [5:0] frm_addr,
  input logic       frm_val0,
  input logic       pwr_down,
  input logic       spi_miso
);
  // R4: state right after reset
  a_r4_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwr_down && !spi_miso));

  // R3: a frame is only committed on a deselect edge
  a_r3_commit_on_deselect: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(cs_rise));

  // R3: one commit per chip-select period
  a_r3_commit_single: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R5: control write drives the power-down flag
  a_r5_pwr_follows_ctrl: assert property (@(posedge clk) disable iff (rst)
    (commit && frm_cmd == 2'd0 && frm_addr == 6'd1) |=> (pwr_down == $past(frm_val0)));

  // R10: no state change without a committed frame
  a_r10_pwr_stable: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(pwr_down));

  // R9: miso quiet while deselected
  a_r9_miso_idle: assert property (@(posedge clk) disable iff (rst)
    $past(cs_hi) |-> !spi_miso);

  // R8: first bit of a readback word is a zero pad bit
  a_r8_pad_first: assert property (@(posedge clk) disable iff (rst)
    $past(cs_fall) |-> !spi_miso);
endmodule

bind dacspi_regslave dacspi_regslave_chk u_chk (
  .clk(clk), .rst(rst),
  .cs_hi(cs_hi), .cs_rise(cs_rise), .cs_fall(cs_fall),
  .commit(commit), .frm_cmd(frm_cmd), .frm_addr(frm_addr), .frm_val0(frm_val0),
  .pwr_down(pwr_down), .spi_miso(spi_miso)
);

// File: tb/dacspi_regslave_tb_top.sv
module dacspi_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 5;
  localparam int NCH        = 16;
  localparam int CPG        = 4;
  localparam int NGRP       = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic miso16, miso14;
  logic [NCH*16-1:0] dat16, ofs16, gain16, dat14, ofs14, gain14;
  logic [NGRP*14-1:0] grp16, grp14;
  logic [NCH*14-1:0]  cgrp16, cgrp14;
  logic pwr16, pwr14;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacspi_regslave #(.NUM_CH(NCH), .DATA_W(16), .CH_PER_GRP(CPG), .NUM_GRP(NGRP)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(miso16), .chan_data(dat16), .chan_offset(ofs16), .chan_gain(gain16),
    .grp_offset(grp16), .chan_grp_offset(cgrp16), .pwr_down(pwr16));

  dacspi_regslave #(.NUM_CH(NCH), .DATA_W(14), .CH_PER_GRP(CPG), .NUM_GRP(NGRP)) dut14_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(miso14), .chan_data(dat14), .chan_offset(ofs14), .chan_gain(gain14),
    .grp_offset(grp14), .chan_grp_offset(cgrp14), .pwr_down(pwr14));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // expected state
  logic [15:0] m_dat [NCH];
  logic [15:0] m_ofs [NCH];
  logic [15:0] m_gain[NCH];
  logic [13:0] m_gofs[NGRP];
  logic [15:0] m_ctrl;
  logic [23:0] rx16, rx14;

  localparam logic [15:0] M14 = 16'hFFFC;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int grp_of(input int c);
    int g = c / CPG;
    return (g < NGRP) ? g : NGRP - 1;
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk({req, " data16"},  32'(dat16[c*16 +: 16]),  32'(m_dat[c]));
      chk({req, " data14"},  32'(dat14[c*16 +: 16]),  32'(m_dat[c] & M14));
      chk({req, " ofs16"},   32'(ofs16[c*16 +: 16]),  32'(m_ofs[c]));
      chk({req, " ofs14"},   32'(ofs14[c*16 +: 16]),  32'(m_ofs[c] & M14));
      chk({req, " gain16"},  32'(gain16[c*16 +: 16]), 32'(m_gain[c]));
      chk({req, " gain14"},  32'(gain14[c*16 +: 16]), 32'(m_gain[c] & M14));
      chk({req, " R7 cgrp"}, 32'(cgrp16[c*14 +: 14]), 32'(m_gofs[grp_of(c)]));
      chk({req, " R7 cgrp14"}, 32'(cgrp14[c*14 +: 14]), 32'(m_gofs[grp_of(c)]));
    end
    for (int g = 0; g < NGRP; g++)
      chk({req, " grp"}, 32'(grp16[g*14 +: 14]), 32'(m_gofs[g]));
    chk({req, " pwr"}, 32'(pwr16), 32'(m_ctrl[0]));
    chk({req, " pwr14"}, 32'(pwr14), 32'(m_ctrl[0]));
  endtask

  task automatic xfer(input int nbits, input logic [23:0] word);
    rx16 = '0;
    rx14 = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 24) ? word[23 - i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 24) begin
        rx16 = {rx16[22:0], miso16};
        rx14 = {rx14[22:0], miso14};
      end
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // full frame plus model update from the requirements
  task automatic wr(input logic [1:0] cmd, input logic [5:0] addr, input logic [15:0] val);
    int a = int'(addr);
    xfer(24, {cmd, addr, val});
    if (cmd != 2'd0) begin
      if (a >= 8 && a < 8 + NCH) begin
        case (cmd)
          2'd3: m_dat[a-8]  = val;
          2'd2: m_ofs[a-8]  = val;
          default: m_gain[a-8] = val;
        endcase
      end
    end else begin
      if (a == 1) m_ctrl = val;
      else if (a >= 2 && a < 2 + NGRP) m_gofs[a-2] = val[13:0];
    end
  endtask

  function automatic logic [15:0] rb_exp(input logic [2:0] sel, input int tgt);
    logic [15:0] r = '0;
    if (tgt >= 8 && tgt < 8 + NCH) begin
      if (sel == 3'd0) r = m_dat[tgt-8];
      if (sel == 3'd2) r = m_ofs[tgt-8];
      if (sel == 3'd3) r = m_gain[tgt-8];
    end
    if (sel == 3'd4) begin
      if (tgt == 1) r = m_ctrl;
      if (tgt >= 2 && tgt < 2 + NGRP) r = {2'b00, m_gofs[tgt-2]};
    end
    return r;
  endfunction

  task automatic rb(input string req, input logic [2:0] sel, input int tgt);
    logic [15:0] e = rb_exp(sel, tgt);
    logic [15:0] e14 = (sel == 3'd4) ? e : (e & M14);
    xfer(24, {2'd0, 6'd5, sel, 6'(tgt), 7'd0});
    xfer(24, 24'h000000);
    chk({req, " rb16"}, 32'(rx16), {16'h0, e});
    chk({req, " rb14"}, 32'(rx14), {16'h0, e14});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_dat[c] = '0; m_ofs[c] = '0; m_gain[c] = 16'hFFFF;
    end
    for (int g = 0; g < NGRP; g++) m_gofs[g] = '0;
    m_ctrl = '0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R4 reset values
    check_all("R4");
    chk("R4 miso", 32'(miso16), 32'd0);

    // R1 data sweep over all channels
    for (int c = 0; c < NCH; c++) wr(2'd3, 6'(c + 8), 16'(c * 4951 + 2655));
    check_all("R1");

    // R2 offset and gain sweeps
    for (int c = 0; c < NCH; c++) wr(2'd2, 6'(c + 8), 16'(c * 7717 + 301) | 16'h0003);
    for (int c = 0; c < NCH; c++) wr(2'd1, 6'(c + 8), 16'(16'hF00F - c * 3001));
    check_all("R2");

    // R6 / R7 group offsets, upper value bits dropped
    wr(2'd0, 6'd2, 16'hEAAA);
    wr(2'd0, 6'd3, 16'h5555);
    check_all("R6");
    chk("R6 grp0", 32'(grp16[13:0]), 32'h2AAA);

    // R5 control register
    wr(2'd0, 6'd1, 16'h00F1);
    check_all("R5");
    chk("R5 pwr set", 32'(pwr16), 32'd1);
    wr(2'd0, 6'd1, 16'h8000);
    chk("R5 pwr clear", 32'(pwr16), 32'd0);

    // R3 wrong-length frames are dropped
    xfer(23, {2'd3, 6'd8, 16'h1111});
    check_all("R3 short");
    xfer(25, {2'd3, 6'd9, 16'h2222});
    check_all("R3 long");
    xfer(23, {2'd0, 6'd5, 3'd0, 6'd8, 7'd0});
    xfer(24, 24'h000000);
    chk("R3 no readback armed", 32'(rx16), 32'd0);

    // R10 unmapped and no-op writes
    wr(2'd3, 6'd3, 16'h3333);
    wr(2'd2, 6'(8 + NCH), 16'h4444);
    wr(2'd1, 6'd63, 16'h5555);
    wr(2'd0, 6'd0, 16'h6666);
    wr(2'd0, 6'd4, 16'h7777);
    wr(2'd0, 6'd6, 16'h8888);
    wr(2'd0, 6'd40, 16'h9999);
    check_all("R10");

    // R8 readback sweep over all channels and banks
    for (int c = 0; c < NCH; c++) begin
      rb("R8 data", 3'd0, c + 8);
      rb("R8 offset", 3'd2, c + 8);
      rb("R8 gain", 3'd3, c + 8);
    end
    rb("R8 ctrl", 3'd4, 1);
    rb("R8 grp0", 3'd4, 2);
    rb("R8 grp1", 3'd4, 3);

    // R11 readbacks that return zero
    rb("R11 kind1", 3'd1, 9);
    rb("R11 kind5", 3'd5, 9);
    rb("R11 kind7", 3'd7, 10);
    rb("R11 chan below", 3'd0, 7);
    rb("R11 chan above", 3'd3, 8 + NCH);
    rb("R11 sf unmapped", 3'd4, 4);

    // R9 only the period right after the request carries the result
    xfer(24, {2'd0, 6'd5, 3'd3, 6'd8, 7'd0});
    xfer(24, 24'h000000);
    chk("R9 result frame", 32'(rx16), {16'h0, m_gain[0]});
    xfer(24, 24'h000000);
    chk("R9 following frame", 32'(rx16), 32'd0);
    chk("R9 idle miso", 32'(miso16), 32'd0);

    // R4 reset again restores defaults
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_dat[c] = '0; m_ofs[c] = '0; m_gain[c] = 16'hFFFF;
    end
    for (int g = 0; g < NGRP; g++) m_gofs[g] = '0;
    m_ctrl = '0;
    check_all("R4 rereset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule